// File: doc/BRIEF.md
# Dual-Width Integer Shift Stage

This block is the combinational shift step of a 64-bit integer execution pipeline. It takes two 64-bit operands: A supplies the data and the low bits of B supply the shift amount. It also takes an opcode, a signed flag, a word-mode flag, a two-bit carry-in field and an opaque operation-context word. In one pass of logic it returns a 64-bit result, a result-valid flag, a two-bit carry-out field and the context word unchanged. The operations are shift left, shift right (logical or arithmetic, chosen by the signed flag) and "sign-extend the low word, then shift left". Each operation runs in full 64-bit mode or in 32-bit word mode.

The shift amount has one bit more than a shift across the operand needs. An amount at or past the data width therefore flushes the whole value out and leaves zeros, or sign copies for an arithmetic right shift. In word mode the amount is six bits and the upper word of the result follows a fixed rule for each operation. One shared barrel shifter carries every variant. A small front end chooses its data, amount, direction and fill bit.

Top module: `shf_exec_unit`

## Requirements
- R1: Opcode 3'd1 (shift left) in 64-bit mode (word_mode=0) returns A shifted left by B[6:0], truncated to 64 bits. Any amount of 64 or more gives zero. B[63:7] have no effect.
- R2: Opcode 3'd1 in word mode (word_mode=1) shifts A left by B[5:0] and keeps only the low 32 bits of that. The upper 32 bits of the result are zero.
- R3: Opcode 3'd2 (shift right) with is_signed=0 in word mode returns A[31:0] shifted right logically by B[5:0] in the low word, with zeros in the upper word.
- R4: Opcode 3'd2 with is_signed=1 in word mode shifts the signed value A[31:0] right by B[5:0] into the low word. Every bit of the upper word equals A[31].
- R5: Opcode 3'd2 with is_signed=0 in 64-bit mode returns A shifted right logically by B[6:0]. Any amount of 64 or more gives zero.
- R6: Opcode 3'd2 with is_signed=1 in 64-bit mode shifts the signed A right by B[6:0]. Any amount of 64 or more gives 64 copies of A[63].
- R7: Opcode 3'd3 first sign-extends A[31:0] to 64 bits. In 64-bit mode it then shifts that value left by B[6:0]. In word mode it shifts left by B[5:0], keeps the low 32 bits and zeroes the upper word. With a zero amount, the low word equals A[31:0].
- R8: For an arithmetic right shift, carry_out[0] is A[63] AND (some 1 bit of A is lost when shifting right by B[6:0]). carry_out[1] is A[31] AND (some 1 bit of A[31:0] is lost when shifting right by B[5:0]). Both bits are computed this way in either mode. For every other operation carry_out is 2'b00. carry_in never affects any output.
- R9: ctx_out always equals ctx_in.
- R10: res_valid is 1 exactly for opcodes 3'd1, 3'd2 and 3'd3. Opcodes 3'd0 and 3'd4 to 3'd7 give res_valid=0, result zero and carry_out zero. is_signed affects only opcode 3'd2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 64 | Data operand A |
| op_b | input | 64 | Amount operand B (low 7 bits used) |
| carry_in | input | 2 | Incoming carry pair (no effect on these operations) |
| opcode | input | 3 | Operation select |
| is_signed | input | 1 | Arithmetic right shift when set |
| word_mode | input | 1 | 32-bit semantics when set |
| ctx_in | input | 16 | Operation context word |
| result | output | 64 | Shift result |
| res_valid | output | 1 | Result produced by a supported operation |
| carry_out | output | 2 | Arithmetic-shift carry pair |
| ctx_out | output | 16 | Context word, unchanged |

## Verification
An arithmetic right shift produces a shifted result and a carry-out in the same evaluation. Both depend on the same amount, but the carry-out reads B[6:0] for bit 0 and B[5:0] for bit 1, whatever the mode. The sweep applies negative and positive operands at amounts 0, 31, 32, 33, 63, 64, 65 and 127 in both modes. For each vector it compares the result with a signed shift computed in the bench and compares each carry bit with a lost-bit mask. Random carry-in and context values ride along on every vector to show that neither disturbs the other outputs.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic [2:0] {
    SHF_NOP   = 3'd0,
    SHF_LEFT  = 3'd1,
    SHF_RIGHT = 3'd2,
    SHF_EXTL  = 3'd3
  } shf_op_e;

  function automatic logic op_known(input logic [2:0] code);
    return (code == SHF_LEFT) || (code == SHF_RIGHT) || (code == SHF_EXTL);
  endfunction
endpackage

// File: rtl/shf_operand_prep.sv
module shf_operand_prep
  import shf_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int AW   = 7
) (
  input  logic [XLEN-1:0] a,
  input  logic [AW-1:0]   b_amt,
  input  logic [2:0]      code,
  input  logic            is_signed,
  input  logic            word_mode,
  output logic [XLEN-1:0] sh_data,
  output logic [AW-1:0]   sh_amt,
  output logic            sh_left,
  output logic            sh_fill,
  output logic            known,
  output logic            is_sra
);
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] sext_word;
  logic [XLEN-1:0] zext_word;

  assign sext_word = {{HALF{a[HALF-1]}}, a[HALF-1:0]};
  assign zext_word = {{HALF{1'b0}}, a[HALF-1:0]};
  assign known     = op_known(code);
  assign is_sra    = (code == SHF_RIGHT) && is_signed;
  assign sh_amt    = word_mode ? {1'b0, b_amt[AW-2:0]} : b_amt;
  assign sh_left   = (code == SHF_LEFT) || (code == SHF_EXTL);
  assign sh_fill   = is_sra ? (word_mode ? a[HALF-1] : a[XLEN-1]) : 1'b0;

  always_comb begin
    case (code)
      SHF_LEFT:  sh_data = a;
      SHF_RIGHT: sh_data = word_mode ? (is_signed ? sext_word : zext_word) : a;
      SHF_EXTL:  sh_data = sext_word;
      default:   sh_data = '0;
    endcase
  end

  // R4
  always_comb begin
    if (word_mode) amt_word_chk: assert (sh_amt[AW-1] == 1'b0);
  end
endmodule

// File: rtl/shf_barrel.sv
module shf_barrel #(
  parameter int W  = 64,
  parameter int AW = 7
) (
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] amt,
  input  logic          shift_left,
  input  logic          fill,
  output logic [W-1:0]  dout
);
  logic [W-1:0] stage [0:AW];

  assign stage[0] = din;

  for (genvar k = 0; k < AW; k++) begin : g_stage
    localparam int S = 1 << k;
    logic [W-1:0] l_v;
    logic [W-1:0] r_v;
    if (S >= W) begin : g_flush
      assign l_v = '0;
      assign r_v = {W{fill}};
    end else begin : g_part
      assign l_v = {stage[k][W-1-S:0], {S{1'b0}}};
      assign r_v = {{S{fill}}, stage[k][W-1:S]};
    end
    assign stage[k+1] = amt[k] ? (shift_left ? l_v : r_v) : stage[k];
  end

  assign dout = stage[AW];

  // R1
  always_comb begin
    if (shift_left && int'(amt) >= W) flush_left_chk: assert (dout == '0);
  end

  // R6
  always_comb begin
    if (!shift_left && int'(amt) >= W) flush_right_chk: assert (dout == {W{fill}});
  end

  // R7
  always_comb begin
    if (amt == '0) zero_amt_chk: assert (dout == din);
  end
endmodule

// File: rtl/shf_carry_detect.sv
module shf_carry_detect #(
  parameter int W  = 64,
  parameter int AW = 7
) (
  input  logic [W-1:0]  a,
  input  logic [AW-1:0] b_amt,
  input  logic          is_sra,
  output logic [1:0]    carry
);
  localparam int H = W / 2;

  function automatic logic [W-1:0] full_mask(input logic [AW-1:0] n);
    return ~({W{1'b1}} << n);
  endfunction

  function automatic logic [H-1:0] half_mask(input logic [AW-2:0] n);
    return ~({H{1'b1}} << n);
  endfunction

  logic lost_full;
  logic lost_half;

  assign lost_full = |(a & full_mask(b_amt));
  assign lost_half = |(a[H-1:0] & half_mask(b_amt[AW-2:0]));
  assign carry     = is_sra ? {a[H-1] & lost_half, a[W-1] & lost_full} : 2'b00;

  // R8
  always_comb begin
    carry_sign_chk: assert ((!carry[0] || a[W-1]) && (!carry[1] || a[H-1]));
  end
endmodule

// File: rtl/shf_exec_unit.sv
module shf_exec_unit
  import shf_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int CTX_W = 16
) (
  input  logic [XLEN-1:0]  op_a,
  input  logic [XLEN-1:0]  op_b,
  input  logic [1:0]       carry_in,
  input  logic [2:0]       opcode,
  input  logic             is_signed,
  input  logic             word_mode,
  input  logic [CTX_W-1:0] ctx_in,
  output logic [XLEN-1:0]  result,
  output logic             res_valid,
  output logic [1:0]       carry_out,
  output logic [CTX_W-1:0] ctx_out
);
  localparam int AW   = $clog2(XLEN) + 1;
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] sh_data;
  logic [AW-1:0]   sh_amt;
  logic            sh_left;
  logic            sh_fill;
  logic            known;
  logic            is_sra;
  logic [XLEN-1:0] raw;
  logic            unused_inputs;

  assign unused_inputs = ^{op_b[XLEN-1:AW], carry_in};

  shf_operand_prep #(.XLEN(XLEN), .AW(AW)) u_prep (
    .a(op_a), .b_amt(op_b[AW-1:0]), .code(opcode), .is_signed(is_signed),
    .word_mode(word_mode), .sh_data(sh_data), .sh_amt(sh_amt),
    .sh_left(sh_left), .sh_fill(sh_fill), .known(known), .is_sra(is_sra)
  );

  shf_barrel #(.W(XLEN), .AW(AW)) u_barrel (
    .din(sh_data), .amt(sh_amt), .shift_left(sh_left), .fill(sh_fill), .dout(raw)
  );

  shf_carry_detect #(.W(XLEN), .AW(AW)) u_carry (
    .a(op_a), .b_amt(op_b[AW-1:0]), .is_sra(is_sra), .carry(carry_out)
  );

  always_comb begin
    if (!known)                     result = '0;
    else if (word_mode && !is_sra)  result = {{HALF{1'b0}}, raw[HALF-1:0]};
    else                            result = raw;
  end

  assign res_valid = known;
  assign ctx_out   = ctx_in;

  // R10
  always_comb begin
    if (!res_valid) idle_zero_chk: assert (result == '0 && carry_out == 2'b00);
  end

  // R2
  always_comb begin
    if (res_valid && word_mode && !is_sra) word_upper_chk: assert (result[XLEN-1:HALF] == '0);
  end

  // R4
  always_comb begin
    if (is_sra && word_mode) sra_word_fill_chk: assert (result[XLEN-1:HALF] == {HALF{op_a[HALF-1]}});
  end

  // R8
  always_comb begin
    if (!is_sra) carry_quiet_chk: assert (carry_out == 2'b00);
  end
endmodule

// File: tb/shf_exec_unit_bench.sv
module shf_exec_unit_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;
  logic rst = 1'b1;

  logic [63:0] a = '0, b = '0;
  logic [1:0]  cin = '0;
  logic [2:0]  opc = '0;
  logic        sg = 1'b0, wd = 1'b0;
  logic [15:0] ctx = '0;
  logic [63:0] res;
  logic        vld;
  logic [1:0]  cout;
  logic [15:0] ctxo;

  int checks = 0;
  int errors = 0;

  shf_exec_unit u_shf_exec_unit (
    .op_a(a), .op_b(b), .carry_in(cin), .opcode(opc), .is_signed(sg),
    .word_mode(wd), .ctx_in(ctx), .result(res), .res_valid(vld),
    .carry_out(cout), .ctx_out(ctxo)
  );

  function automatic string tag_of(input int op, input bit s, input bit w);
    if (op == 1) return w ? "R2" : "R1";
    if (op == 2) return s ? (w ? "R4" : "R6") : (w ? "R3" : "R5");
    if (op == 3) return "R7";
    return "R10";
  endfunction

  function automatic logic [63:0] model_res(input int op, input bit s, input bit w,
                                            input logic [63:0] x, input logic [63:0] y);
    logic [63:0] sx;
    logic [31:0] lo;
    logic signed [31:0] s32;
    sx = {{32{x[31]}}, x[31:0]};
    case (op)
      1: begin
        if (w) begin lo = 32'(x << y[5:0]); return {32'h0, lo}; end
        return x << y[6:0];
      end
      2: begin
        if (!s && w) begin lo = x[31:0] >> y[5:0]; return {32'h0, lo}; end
        if (!s) return x >> y[6:0];
        if (w) begin s32 = $signed(x[31:0]) >>> y[5:0]; return {{32{x[31]}}, s32}; end
        return $signed(x) >>> y[6:0];
      end
      3: begin
        if (w) begin lo = 32'(sx << y[5:0]); return {32'h0, lo}; end
        return sx << y[6:0];
      end
      default: return 64'h0;
    endcase
  endfunction

  function automatic logic [1:0] model_carry(input int op, input bit s,
                                             input logic [63:0] x, input logic [63:0] y);
    logic l64, l32;
    if (!(op == 2 && s)) return 2'b00;
    l64 = |(x & ~(64'hFFFF_FFFF_FFFF_FFFF << y[6:0]));
    l32 = |(x[31:0] & ~(32'hFFFF_FFFF << y[5:0]));
    return {x[31] & l32, x[63] & l64};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (op=%0d s=%0b w=%0b a=%h b=%h)",
               tag, act, exp, opc, sg, wd, a, b);
    end
  endtask

  task automatic apply(input int op, input bit s, input bit w,
                       input logic [63:0] x, input logic [63:0] y);
    @(posedge clk);
    opc = 3'(op); sg = s; wd = w; a = x; b = y;
    cin = 2'($urandom); ctx = 16'($urandom);
    @(negedge clk);
    check(tag_of(op, s, w), res, model_res(op, s, w, x, y));
    check("R10", {63'h0, vld}, {63'h0, (op >= 1 && op <= 3)});
    check("R8", {62'h0, cout}, {62'h0, model_carry(op, s, x, y)});
    check("R9", {48'h0, ctxo}, {48'h0, ctx});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements): actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] ops [6];
    int amts [12];
    ops[0] = 64'h0123_4567_89AB_CDEF;
    ops[1] = 64'hFEDC_BA98_7654_3210;
    ops[2] = 64'h8000_0000_8000_0001;
    ops[3] = 64'h7FFF_FFFF_7FFF_FFFF;
    ops[4] = {1'b1, 63'($urandom)} ^ {32'h0, $urandom};
    ops[5] = {1'b0, 31'($urandom), 1'b0, 31'($urandom)};
    amts[0] = 0;  amts[1] = 1;  amts[2] = 31; amts[3] = 32;
    amts[4] = 33; amts[5] = 63; amts[6] = 64; amts[7] = 65;
    amts[8] = 127;
    for (int i = 9; i < 12; i++) amts[i] = int'($urandom % 128);

    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10", res, 64'h0);
    check("R10", {63'h0, vld}, 64'h0);
    rst = 1'b0;

    for (int op = 0; op < 8; op++)
      for (int s = 0; s < 2; s++)
        for (int w = 0; w < 2; w++)
          for (int i = 0; i < 6; i++)
            for (int k = 0; k < 12; k++)
              apply(op, s[0], w[0], ops[i],
                    {$urandom, 25'($urandom), 7'(amts[k])});

    // R7: zero amount keeps the low word of A
    apply(3, 1'b0, 1'b1, 64'hAAAA_5555_8765_4321, 64'h0);
    check("R7", {32'h0, res[31:0]}, 64'h8765_4321);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule